// File: doc/BRIEF.md
# Scan-Testable Modulo-3 Counter

This block is a two-bit counter that cycles through three codes and raises a flag in its final code. It counts while its enable input is high and keeps its value while the enable is low. A synchronous clear input returns it to zero. The flag output is high only in the top code of the count.

Each of the two state flops has a multiplexer on its D input, so the same flops also form a serial chain. When the test-mode input is high, the flops stop counting and shift instead. The first flop takes the serial input, the second flop takes the first flop's old value, and the second flop drives the serial output. A tester can therefore load any state, including the spare code 3, run one functional clock, and shift the result out.

The state encoding is binary: code n is state_o = n. The first flop in the chain holds state_o[0] and the last flop holds state_o[1]. All flops use one primary clock, and the clock drives no data input and passes through no gate.

Top module: `mod3_scan_counter`

## Requirements
- R1: With test_mode=0 and sync_rst=1, the state is 0 after the next rising edge, whatever cnt_en is.
- R2: With test_mode=0, sync_rst=0 and cnt_en=1, the state moves 0→1, 1→2 and 2→0 on each rising edge.
- R3: With test_mode=0, sync_rst=0 and cnt_en=0, the state is unchanged on the edge, for every code including 3.
- R4: With test_mode=0, sync_rst=0 and cnt_en=1, the spare code 3 goes to 0.
- R5: hit_o is 1 exactly when state_o equals 2 (binary 10), and 0 for codes 0, 1 and 3.
- R6: With test_mode=1, each edge loads state_o[0] from scan_in and state_o[1] from the old state_o[0]. cnt_en and sync_rst have no effect.
- R7: scan_out always equals state_o[1], the last flop of the chain, in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Primary clock, rising edge |
| cnt_en | input | 1 | Count enable in normal mode |
| sync_rst | input | 1 | Synchronous clear, active high, normal mode only |
| test_mode | input | 1 | 1 selects the serial scan path for both flops |
| scan_in | input | 1 | Serial data into the first flop |
| hit_o | output | 1 | High when the state is 2 |
| scan_out | output | 1 | Serial data from the last flop |
| state_o | output | 2 | Current state; bit 0 is the first flop in the chain |

## Verification
The bench loads each of the four codes through the chain and then applies every combination of enable and clear in normal mode, so all state transitions are covered. The most likely defect is in the spare code 3. A counter that incremented blindly would wrap 3 to 0 only by accident of width, and a decoder that tested a single bit would raise the flag in 3. The bench also drives clear and enable high while shifting. A design that let clear act in test mode would zero the chain, and one that wired the chain in the wrong order would return the shifted bits swapped at scan_out.

// File: rtl/mod3_scan_pkg.sv
package mod3_scan_pkg;

    // Register image of one scan flop
    typedef struct packed {
        logic bit_v;
    } cell_t;

endpackage

// File: rtl/m3_next_state.sv
module m3_next_state #(
    parameter int MOD_N = 3,
    parameter int W     = $clog2(MOD_N)
) (
    input  logic [W-1:0] state_i,
    input  logic         cnt_en,
    input  logic         sync_rst,
    output logic [W-1:0] func_d
);
    localparam logic [W-1:0] LAST = W'(MOD_N - 1);

    always_comb begin
        if (sync_rst) begin
            func_d = '0;
        end else if (cnt_en) begin
            // Top code and any unused code above it wrap to zero
            func_d = (state_i >= LAST) ? '0 : state_i + W'(1);
        end else begin
            func_d = state_i;
        end
    end
endmodule

// File: rtl/m3_scan_cell.sv
module m3_scan_cell
    import mod3_scan_pkg::*;
(
    input  logic clk,
    input  logic test_mode,
    input  logic func_d,
    input  logic scan_d,
    output logic q
);
    cell_t cell_d, cell_q;

    always_comb begin
        cell_d.bit_v = test_mode ? scan_d : func_d;
    end

    always_ff @(posedge clk) begin
        cell_q <= cell_d;
    end

    assign q = cell_q.bit_v;
endmodule

// File: rtl/m3_decode.sv
module m3_decode #(
    parameter int MOD_N = 3,
    parameter int W     = $clog2(MOD_N)
) (
    input  logic [W-1:0] state_i,
    output logic         hit_o
);
    localparam logic [W-1:0] LAST = W'(MOD_N - 1);

    always_comb begin
        hit_o = (state_i == LAST);
    end
endmodule

// File: rtl/mod3_scan_counter.sv
module mod3_scan_counter #(
    parameter int MOD_N = 3,
    localparam int W    = $clog2(MOD_N)
) (
    input  logic         clk,
    input  logic         cnt_en,
    input  logic         sync_rst,
    input  logic         test_mode,
    input  logic         scan_in,
    output logic         hit_o,
    output logic         scan_out,
    output logic [W-1:0] state_o
);
    logic [W-1:0] func_d;
    logic [W-1:0] state_q;
    logic [W:0]   chain;

    m3_next_state #(.MOD_N(MOD_N), .W(W)) u_next (
        .state_i  (state_q),
        .cnt_en   (cnt_en),
        .sync_rst (sync_rst),
        .func_d   (func_d)
    );

    // Serial path: scan_in -> bit 0 -> bit 1 -> ... -> scan_out
    assign chain[0] = scan_in;

    for (genvar i = 0; i < W; i++) begin : g_cell
        m3_scan_cell u_cell (
            .clk       (clk),
            .test_mode (test_mode),
            .func_d    (func_d[i]),
            .scan_d    (chain[i]),
            .q         (state_q[i])
        );
        assign chain[i+1] = state_q[i];
    end

    m3_decode #(.MOD_N(MOD_N), .W(W)) u_dec (
        .state_i (state_q),
        .hit_o   (hit_o)
    );

    assign scan_out = chain[W];
    assign state_o  = state_q;
endmodule

// File: rtl/m3_scan_chk.sv
module m3_scan_chk (
    input logic       clk,
    input logic       cnt_en,
    input logic       sync_rst,
    input logic       test_mode,
    input logic       scan_in,
    input logic       hit_o,
    input logic       scan_out,
    input logic [1:0] state_o
);
    // Becomes 1 once a normal-mode clear has given the flops a known value
    logic known_q = 1'b0;
    always_ff @(posedge clk) begin
        if (!test_mode && sync_rst) known_q <= 1'b1;
    end

    AST_CLEAR: assert property (@(posedge clk) (!test_mode && sync_rst) |=> state_o == 2'b00); // R1
    AST_STEP_0: assert property (@(posedge clk) disable iff (!known_q)
        (!test_mode && !sync_rst && cnt_en && state_o == 2'b00) |=> state_o == 2'b01); // R2
    AST_STEP_1: assert property (@(posedge clk) disable iff (!known_q)
        (!test_mode && !sync_rst && cnt_en && state_o == 2'b01) |=> state_o == 2'b10); // R2
    AST_STEP_2: assert property (@(posedge clk) disable iff (!known_q)
        (!test_mode && !sync_rst && cnt_en && state_o == 2'b10) |=> state_o == 2'b00); // R2
    AST_HOLD: assert property (@(posedge clk) disable iff (!known_q)
        (!test_mode && !sync_rst && !cnt_en) |=> $stable(state_o)); // R3
    AST_SPARE: assert property (@(posedge clk) disable iff (!known_q)
        (!test_mode && !sync_rst && cnt_en && state_o == 2'b11) |=> state_o == 2'b00); // R4
    AST_FLAG: assert property (@(posedge clk) disable iff (!known_q)
        hit_o == (state_o == 2'b10)); // R5
    AST_SHIFT: assert property (@(posedge clk) disable iff (!known_q)
        test_mode |=> (state_o[0] == $past(scan_in)) && (state_o[1] == $past(state_o[0]))); // R6
    AST_SO: assert property (@(posedge clk) disable iff (!known_q)
        scan_out == state_o[1]); // R7
endmodule

bind mod3_scan_counter m3_scan_chk u_chk (
    .clk       (clk),
    .cnt_en    (cnt_en),
    .sync_rst  (sync_rst),
    .test_mode (test_mode),
    .scan_in   (scan_in),
    .hit_o     (hit_o),
    .scan_out  (scan_out),
    .state_o   (state_o)
);

// File: tb/tb_mod3_scan_counter.sv
`timescale 1ns/1ps
module tb_mod3_scan_counter;
    logic       clk = 1'b0;
    logic       cnt_en = 1'b0;
    logic       sync_rst = 1'b0;
    logic       test_mode = 1'b0;
    logic       scan_in = 1'b0;
    logic       hit_o;
    logic       scan_out;
    logic [1:0] state_o;

    int n_run  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;  // 50 MHz

    mod3_scan_counter dut (
        .clk       (clk),
        .cnt_en    (cnt_en),
        .sync_rst  (sync_rst),
        .test_mode (test_mode),
        .scan_in   (scan_in),
        .hit_o     (hit_o),
        .scan_out  (scan_out),
        .state_o   (state_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive at the falling edge, return 1 ns after the rising edge
    task automatic step(input logic en, input logic rst, input logic tm, input logic si);
        @(negedge clk);
        cnt_en = en; sync_rst = rst; test_mode = tm; scan_in = si;
        @(posedge clk);
        #1;
    endtask

    function automatic int next_code(input int s, input int en, input int rst);
        if (rst != 0) return 0;
        if (en == 0)  return s;
        return (s + 1) % 3 == 0 || s == 3 ? 0 : s + 1;
    endfunction

    // Outputs that depend only on the state: R5 and R7
    task automatic chk_outs(input int s);
        chk("R5", int'(hit_o), (s == 2) ? 1 : 0);
        chk("R7", int'(scan_out), (s >> 1) & 1);
    endtask

    initial begin
        // Reset state
        step(1'b1, 1'b1, 1'b0, 1'b1);
        chk("R1", int'(state_o), 0);
        chk_outs(0);

        // Free-running count sequence from 0
        for (int k = 1; k <= 7; k++) begin
            step(1'b1, 1'b0, 1'b0, 1'b0);
            chk("R2", int'(state_o), k % 3);
            chk_outs(k % 3);
        end

        // Every start code x every enable/clear combination
        for (int s = 0; s < 4; s++) begin
            for (int m = 0; m < 4; m++) begin
                int en  = m & 1;
                int rst = (m >> 1) & 1;
                int exp;
                // Load through the chain with clear and enable held high (R6)
                step(1'b1, 1'b1, 1'b1, 1'((s >> 1) & 1));
                chk("R6", int'(state_o[0]), (s >> 1) & 1);
                step(1'b1, 1'b1, 1'b1, 1'(s & 1));
                chk("R6", int'(state_o), s);
                chk_outs(s);
                // One functional clock
                step(1'(en), 1'(rst), 1'b0, 1'b0);
                exp = next_code(s, en, rst);
                if (rst != 0)       chk("R1", int'(state_o), exp);
                else if (en == 0)   chk("R3", int'(state_o), exp);
                else if (s == 3)    chk("R4", int'(state_o), exp);
                else                chk("R2", int'(state_o), exp);
                chk_outs(exp);
                // Unload: scan_out shows bit 1 now, then bit 0 after one shift
                chk("R7", int'(scan_out), (exp >> 1) & 1);
                step(1'b0, 1'b1, 1'b1, 1'b0);
                chk("R7", int'(scan_out), exp & 1);
                chk("R6", int'(state_o), (exp & 1) << 1);
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 20);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule